// File: doc/BRIEF.md
# Triggered Command Replay Sequencer

This block holds a short program of bus transfer command words and a separate table of outgoing payload words. Software loads both tables through a simple word-write port, sets the number of commands to run and selects replay mode. A single-cycle trigger then replays the stored program as one burst, with no software involvement per transfer.

Each command is offered on a valid/ready command port. A write command streams its payload bytes on an 8-bit valid/ready data-out port. The payload pointer moves by walking the program, so each write picks up where the previous write left off. A read command accepts bytes on an 8-bit data-in port and packs them into 32-bit words on a valid/ready result stream. At the end of the burst both the command index and the payload pointer go back to entry 0, so every trigger replays identical content. The serial bus engine that consumes the commands is a separate block.

Top module: `cmd_replay_seq`

## Requirements
- R1: After reset, busy_o, cmd_valid_o, dout_valid_o, din_ready_o and rd_valid_o are all low.
- R2: A write with mem_we_i high stores mem_wdata_i at entry mem_waddr_i of the command table when mem_wsel_i=0, or of the payload table when mem_wsel_i=1. mem_rdata_o returns the entry chosen by mem_rsel_i and mem_raddr_i, using the same encoding.
- R3: A trigger starts a burst only when the block is idle, mode_i=1 and burst_len_i is nonzero. A trigger with mode_i=0 or with burst_len_i=0 is ignored: busy_o stays low and no command is issued.
- R4: A burst issues command table entries 0 to burst_len_i-1 in order on cmd_o. The burst length is sampled when the trigger is accepted.
- R5: A command word has bit 0 as read-not-write and bits [19:8] as the payload length L. A write (bit 0 = 0) sends L bytes on dout_o, least significant byte of each payload entry first, and runs on into the following entries if needed. The next write starts on a fresh entry. A write with L=0 sends no bytes.
- R6: A read (bit 0 = 1) accepts bytes on din_i. It packs them least significant byte first into 32-bit words, and emits a word on rd_data_o once four bytes are gathered. Reads do not move the payload pointer.
- R7: A read ends after L bytes, or earlier at a byte that has din_last_i set. A partial final word is emitted with its unused upper bytes set to zero.
- R8: When a burst ends, the payload pointer returns to entry 0. Any later trigger replays the program from command 0 and payload entry 0.
- R9: A trigger that arrives while a burst is running is ignored.
- R10: busy_o goes high in the cycle after the trigger is accepted. It stays high until the last command has been handshaken and all of its data has moved. No handshake side is active while busy_o is low.
- R11: While cmd_valid_o, dout_valid_o or rd_valid_o is high and the matching ready input is low, that valid stays high and its data stays unchanged.
- R12: At most one of cmd_valid_o, dout_valid_o, din_ready_o and rd_valid_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_we_i | input | 1 | Table write strobe |
| mem_wsel_i | input | 1 | Write target: 0 command table, 1 payload table |
| mem_waddr_i | input | 4 | Table write entry |
| mem_wdata_i | input | 32 | Table write word |
| mem_rsel_i | input | 1 | Read-back source: 0 command table, 1 payload table |
| mem_raddr_i | input | 4 | Read-back entry |
| mem_rdata_o | output | 32 | Read-back word |
| mode_i | input | 1 | 1 selects replay, 0 direct operation |
| burst_len_i | input | 4 | Commands per burst |
| trig_i | input | 1 | Burst start pulse |
| busy_o | output | 1 | Burst in progress |
| cmd_valid_o | output | 1 | Command valid |
| cmd_ready_i | input | 1 | Command ready |
| cmd_o | output | 32 | Command word |
| dout_valid_o | output | 1 | Payload byte valid |
| dout_ready_i | input | 1 | Payload byte ready |
| dout_o | output | 8 | Payload byte |
| din_valid_i | input | 1 | Read byte valid |
| din_ready_o | output | 1 | Read byte ready |
| din_i | input | 8 | Read byte |
| din_last_i | input | 1 | Final byte of a read |
| rd_valid_o | output | 1 | Packed read word valid |
| rd_ready_i | input | 1 | Packed read word ready |
| rd_data_o | output | 32 | Packed read word |

## Verification
The hold properties assume that downstream consumers may withhold ready for any number of cycles. The bench therefore runs one burst with every ready input toggling, so that each valid meets back-pressure. The mode-gating property assumes that mode_i is stable around a trigger. The stimulus changes mode_i only while the block is idle, and changes it at a falling edge. Read bytes are offered only while the source queue holds data. The din_last_i flag is raised on exactly one scripted byte, so the early-end path is taken deliberately and is never caused by a stray flag.

// File: rtl/replay_pkg.sv
package replay_pkg;
  localparam int RNW_BIT = 0;
  localparam int LEN_LSB = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WR,
    ST_RD,
    ST_EMIT,
    ST_NEXT
  } seq_state_e;
endpackage

// File: rtl/replay_mem.sv
module replay_mem #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_a_i,
  output logic [WORD_W-1:0] rdata_a_o,
  input  logic [AW-1:0]     raddr_b_i,
  output logic [WORD_W-1:0] rdata_b_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/replay_byte_sel.sv
module replay_byte_sel #(
  parameter int WORD_W  = 32,
  parameter int BYTE_W  = 8,
  localparam int LANES  = WORD_W / BYTE_W,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [LANE_W-1:0] lane_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [BYTE_W-1:0] lanes [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = word_i[g*BYTE_W +: BYTE_W];
  end

  assign byte_o = lanes[lane_i];
endmodule

// File: rtl/cmd_replay_seq.sv
module cmd_replay_seq
  import replay_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 12,
  localparam int AW     = $clog2(DEPTH),
  localparam int LANES  = WORD_W / BYTE_W,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mem_we_i,
  input  logic              mem_wsel_i,
  input  logic [AW-1:0]     mem_waddr_i,
  input  logic [WORD_W-1:0] mem_wdata_i,
  input  logic              mem_rsel_i,
  input  logic [AW-1:0]     mem_raddr_i,
  output logic [WORD_W-1:0] mem_rdata_o,
  input  logic              mode_i,
  input  logic [AW-1:0]     burst_len_i,
  input  logic              trig_i,
  output logic              busy_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [WORD_W-1:0] cmd_o,
  output logic              dout_valid_o,
  input  logic              dout_ready_i,
  output logic [BYTE_W-1:0] dout_o,
  input  logic              din_valid_i,
  output logic              din_ready_o,
  input  logic [BYTE_W-1:0] din_i,
  input  logic              din_last_i,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [WORD_W-1:0] rd_data_o
);
  seq_state_e        state_q;
  logic [AW-1:0]     cidx_q, pptr_q, blen_q;
  logic [LEN_W-1:0]  bcnt_q, len_q;
  logic              rd_fin_q;
  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] cmd_word, pay_word, cmd_rb, pay_rb;
  logic [LANE_W-1:0] lane;
  logic [LEN_W-1:0]  cmd_len;
  logic              rd_last;

  replay_mem #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_cmd_mem (
    .clk_i, .rst_ni,
    .we_i(mem_we_i && !mem_wsel_i), .waddr_i(mem_waddr_i), .wdata_i(mem_wdata_i),
    .raddr_a_i(cidx_q), .rdata_a_o(cmd_word),
    .raddr_b_i(mem_raddr_i), .rdata_b_o(cmd_rb)
  );

  replay_mem #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_pay_mem (
    .clk_i, .rst_ni,
    .we_i(mem_we_i && mem_wsel_i), .waddr_i(mem_waddr_i), .wdata_i(mem_wdata_i),
    .raddr_a_i(pptr_q), .rdata_a_o(pay_word),
    .raddr_b_i(mem_raddr_i), .rdata_b_o(pay_rb)
  );

  assign lane = bcnt_q[LANE_W-1:0];

  replay_byte_sel #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_byte_sel (
    .word_i(pay_word), .lane_i(lane), .byte_o(dout_o)
  );

  assign mem_rdata_o = mem_rsel_i ? pay_rb : cmd_rb;
  assign cmd_len     = cmd_word[LEN_LSB +: LEN_W];
  assign rd_last     = (LEN_W'(bcnt_q + 1'b1) == len_q) || din_last_i;

  assign busy_o       = (state_q != ST_IDLE);
  assign cmd_valid_o  = (state_q == ST_CMD);
  assign cmd_o        = cmd_word;
  assign dout_valid_o = (state_q == ST_WR);
  assign din_ready_o  = (state_q == ST_RD);
  assign rd_valid_o   = (state_q == ST_EMIT);
  assign rd_data_o    = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cidx_q   <= '0;
      pptr_q   <= '0;
      blen_q   <= '0;
      bcnt_q   <= '0;
      len_q    <= '0;
      rd_fin_q <= 1'b0;
      acc_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (trig_i && mode_i && (burst_len_i != '0)) begin
            blen_q  <= burst_len_i;
            cidx_q  <= '0;
            pptr_q  <= '0;
            state_q <= ST_CMD;
          end
        end
        ST_CMD: begin
          if (cmd_ready_i) begin
            len_q  <= cmd_len;
            bcnt_q <= '0;
            acc_q  <= '0;
            if (cmd_len == '0)            state_q <= ST_NEXT;
            else if (cmd_word[RNW_BIT])   state_q <= ST_RD;
            else                          state_q <= ST_WR;
          end
        end
        ST_WR: begin
          if (dout_ready_i) begin
            if (bcnt_q == len_q - 1'b1) begin
              // next write starts on a fresh payload entry
              pptr_q  <= pptr_q + 1'b1;
              state_q <= ST_NEXT;
            end else begin
              bcnt_q <= bcnt_q + 1'b1;
              if (lane == LANE_W'(LANES - 1)) pptr_q <= pptr_q + 1'b1;
            end
          end
        end
        ST_RD: begin
          if (din_valid_i) begin
            for (int k = 0; k < LANES; k++) begin
              if (lane == LANE_W'(k)) acc_q[k*BYTE_W +: BYTE_W] <= din_i;
            end
            bcnt_q <= bcnt_q + 1'b1;
            if (rd_last || lane == LANE_W'(LANES - 1)) begin
              rd_fin_q <= rd_last;
              state_q  <= ST_EMIT;
            end
          end
        end
        ST_EMIT: begin
          if (rd_ready_i) begin
            acc_q   <= '0;
            state_q <= rd_fin_q ? ST_NEXT : ST_RD;
          end
        end
        ST_NEXT: begin
          if (cidx_q == blen_q - 1'b1) begin
            cidx_q  <= '0;
            pptr_q  <= '0;
            state_q <= ST_IDLE;
          end else begin
            cidx_q  <= cidx_q + 1'b1;
            state_q <= ST_CMD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmd_replay_seq_chk.sv
module cmd_replay_seq_chk #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_i,
  input logic              trig_i,
  input logic              busy_o,
  input logic              cmd_valid_o,
  input logic              cmd_ready_i,
  input logic [WORD_W-1:0] cmd_o,
  input logic              dout_valid_o,
  input logic              dout_ready_i,
  input logic [BYTE_W-1:0] dout_o,
  input logic              din_ready_o,
  input logic              rd_valid_o,
  input logic              rd_ready_i,
  input logic [WORD_W-1:0] rd_data_o
);
  assert_mode_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && trig_i && !mode_i) |=> !busy_o);

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o || dout_valid_o || din_ready_o || rd_valid_o) |-> busy_o);

  assert_cmd_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_o)));

  assert_dout_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dout_valid_o && !dout_ready_i) |=> (dout_valid_o && $stable(dout_o)));

  assert_rd_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o)));

  assert_one_side_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_valid_o, dout_valid_o, din_ready_o, rd_valid_o}));
endmodule

bind cmd_replay_seq cmd_replay_seq_chk #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .trig_i(trig_i), .busy_o(busy_o),
  .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i), .cmd_o(cmd_o),
  .dout_valid_o(dout_valid_o), .dout_ready_i(dout_ready_i), .dout_o(dout_o),
  .din_ready_o(din_ready_o), .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i),
  .rd_data_o(rd_data_o)
);

// File: tb/cmd_replay_seq_test.sv
`timescale 1ns/1ps
module cmd_replay_seq_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mem_we_i = 1'b0, mem_wsel_i = 1'b0, mem_rsel_i = 1'b0;
  logic [3:0]  mem_waddr_i = '0, mem_raddr_i = '0;
  logic [31:0] mem_wdata_i = '0, mem_rdata_o;
  logic        mode_i = 1'b0, trig_i = 1'b0, busy_o;
  logic [3:0]  burst_len_i = '0;
  logic        cmd_valid_o, cmd_ready_i = 1'b1;
  logic [31:0] cmd_o;
  logic        dout_valid_o, dout_ready_i = 1'b1;
  logic [7:0]  dout_o;
  logic        din_valid_i = 1'b0, din_ready_o, din_last_i = 1'b0;
  logic [7:0]  din_i = '0;
  logic        rd_valid_o, rd_ready_i = 1'b1;
  logic [31:0] rd_data_o;

  int checks = 0, errors = 0;

  always #2 clk_i = ~clk_i;

  cmd_replay_seq uut (
    .clk_i, .rst_ni, .mem_we_i, .mem_wsel_i, .mem_waddr_i, .mem_wdata_i,
    .mem_rsel_i, .mem_raddr_i, .mem_rdata_o, .mode_i, .burst_len_i, .trig_i,
    .busy_o, .cmd_valid_o, .cmd_ready_i, .cmd_o, .dout_valid_o, .dout_ready_i,
    .dout_o, .din_valid_i, .din_ready_o, .din_i, .din_last_i, .rd_valid_o,
    .rd_ready_i, .rd_data_o
  );

  // bench-side table models and logs
  logic [31:0] cmd_m [16];
  logic [31:0] pay_m [16];
  logic [31:0] cmd_log [64];
  logic [7:0]  byte_log [256];
  logic [31:0] rd_log [64];
  logic [7:0]  din_src [64];
  int n_cmd = 0, n_byte = 0, n_rd = 0, multi_side = 0;
  int din_n = 0, din_p = 0, din_last_at = -1;
  bit stall = 0, tog = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive readies / read bytes and log handshakes that the next edge completes
  always @(negedge clk_i) begin
    tog = ~tog;
    cmd_ready_i  = !stall || tog;
    dout_ready_i = !stall || !tog;
    rd_ready_i   = !stall || tog;
    din_valid_i  = (din_p < din_n) && (!stall || tog);
    din_i        = din_src[din_p % 64];
    din_last_i   = din_valid_i && (din_p == din_last_at);
    if (rst_ni) begin
      if (int'(cmd_valid_o) + int'(dout_valid_o) + int'(din_ready_o) + int'(rd_valid_o) > 1)
        multi_side++;
      if (cmd_valid_o && cmd_ready_i) begin cmd_log[n_cmd % 64] = cmd_o; n_cmd++; end
      if (dout_valid_o && dout_ready_i) begin byte_log[n_byte % 256] = dout_o; n_byte++; end
      if (rd_valid_o && rd_ready_i) begin rd_log[n_rd % 64] = rd_data_o; n_rd++; end
      if (din_valid_i && din_ready_o) din_p++;
    end
  end

  function automatic logic [31:0] mk_cmd(input bit rnw, input int len);
    return {12'h000, 12'(len), 7'h2a, rnw};
  endfunction

  task automatic wr_mem(input bit sel, input int idx, input logic [31:0] w);
    @(negedge clk_i);
    mem_we_i = 1'b1; mem_wsel_i = sel; mem_waddr_i = 4'(idx); mem_wdata_i = w;
    @(negedge clk_i);
    mem_we_i = 1'b0;
    if (sel) pay_m[idx] = w; else cmd_m[idx] = w;
  endtask

  task automatic clear_logs();
    n_cmd = 0; n_byte = 0; n_rd = 0; din_p = 0; din_n = 0; din_last_at = -1;
  endtask

  // pulse trigger; optionally check busy rises; wait for burst end
  task automatic fire(input bit expect_busy, input string req);
    @(negedge clk_i);
    trig_i = 1'b1;
    @(negedge clk_i);
    trig_i = 1'b0;
    check(busy_o == expect_busy, req, "busy after trigger", 32'(busy_o), 32'(expect_busy));
    for (int i = 0; i < 3000 && busy_o; i++) @(negedge clk_i);
    check(!busy_o, req, "burst completes", 32'(busy_o), 32'h0);
  endtask

  // expected outgoing bytes: walk commands, writes consume whole entries
  task automatic check_bytes(input int blen, input string req);
    int p = 0, k = 0;
    for (int c = 0; c < blen; c++) begin
      int len = int'(cmd_m[c][19:8]);
      if (!cmd_m[c][0]) begin
        for (int b = 0; b < len; b++) begin
          logic [7:0] e = pay_m[(p + b / 4) % 16][(b % 4) * 8 +: 8];
          if (k < n_byte)
            check(byte_log[k] == e, req, $sformatf("byte %0d", k), 32'(byte_log[k]), 32'(e));
          k++;
        end
        p += (len + 3) / 4;
      end
    end
    check(n_byte == k, req, "byte count", 32'(n_byte), 32'(k));
  endtask

  task automatic check_cmds(input int blen, input string req);
    check(n_cmd == blen, req, "command count", 32'(n_cmd), 32'(blen));
    for (int c = 0; c < blen && c < n_cmd; c++)
      check(cmd_log[c] == cmd_m[c], req, $sformatf("command %0d", c), cmd_log[c], cmd_m[c]);
  endtask

  task automatic t_reset();
    check(!busy_o && !cmd_valid_o && !dout_valid_o && !din_ready_o && !rd_valid_o,
          "R1", "idle outputs after reset",
          {27'h0, busy_o, cmd_valid_o, dout_valid_o, din_ready_o, rd_valid_o}, 32'h0);
  endtask

  task automatic t_mem();
    wr_mem(1'b0, 7, 32'hDEAD_BEEF);
    wr_mem(1'b1, 7, 32'h1234_5678);
    mem_rsel_i = 1'b0; mem_raddr_i = 4'd7; #1;
    check(mem_rdata_o == 32'hDEAD_BEEF, "R2", "command readback", mem_rdata_o, 32'hDEAD_BEEF);
    mem_rsel_i = 1'b1; #1;
    check(mem_rdata_o == 32'h1234_5678, "R2", "payload readback", mem_rdata_o, 32'h1234_5678);
  endtask

  task automatic load_write_prog();
    for (int k = 0; k < 16; k++) wr_mem(1'b1, k, 32'h1310_0F0C + k * 32'h0404_0404);
    wr_mem(1'b0, 0, mk_cmd(1'b0, 3));
    wr_mem(1'b0, 1, mk_cmd(1'b0, 2));
    wr_mem(1'b0, 2, mk_cmd(1'b0, 6));
    wr_mem(1'b0, 3, mk_cmd(1'b0, 0));
    wr_mem(1'b0, 4, mk_cmd(1'b0, 1));
  endtask

  task automatic t_ignored();
    load_write_prog();
    clear_logs();
    mode_i = 1'b0; burst_len_i = 4'd5;
    fire(1'b0, "R3");
    repeat (5) @(negedge clk_i);
    check(n_cmd == 0, "R3", "mode 0 issues nothing", 32'(n_cmd), 32'h0);
    mode_i = 1'b1; burst_len_i = 4'd0;
    fire(1'b0, "R3");
    repeat (5) @(negedge clk_i);
    check(n_cmd == 0, "R3", "zero length issues nothing", 32'(n_cmd), 32'h0);
  endtask

  task automatic t_write();
    clear_logs();
    mode_i = 1'b1; burst_len_i = 4'd5;
    fire(1'b1, "R10");
    check_cmds(5, "R4");
    check_bytes(5, "R5");
  endtask

  task automatic t_replay();
    clear_logs();
    burst_len_i = 4'd2;
    fire(1'b1, "R8");
    check_bytes(2, "R8");
    clear_logs();
    burst_len_i = 4'd5;
    fire(1'b1, "R8");
    check_bytes(5, "R8");
  endtask

  task automatic t_busy_stall();
    clear_logs();
    stall = 1;
    burst_len_i = 4'd5;
    @(negedge clk_i); trig_i = 1'b1;
    @(negedge clk_i); trig_i = 1'b0;
    check(busy_o, "R10", "busy high after accept", 32'(busy_o), 32'h1);
    repeat (6) @(negedge clk_i);
    trig_i = 1'b1;
    @(negedge clk_i); trig_i = 1'b0;
    for (int i = 0; i < 3000 && busy_o; i++) @(negedge clk_i);
    repeat (8) @(negedge clk_i);
    check(!busy_o, "R9", "no second burst", 32'(busy_o), 32'h0);
    check_cmds(5, "R9");
    check_bytes(5, "R11");
    stall = 0;
  endtask

  task automatic t_read();
    logic [31:0] exp [4];
    wr_mem(1'b0, 0, mk_cmd(1'b1, 6));
    wr_mem(1'b0, 1, mk_cmd(1'b1, 3));
    wr_mem(1'b0, 2, mk_cmd(1'b1, 10));
    wr_mem(1'b0, 3, mk_cmd(1'b0, 2));
    clear_logs();
    for (int i = 0; i < 9; i++) din_src[i] = 8'(8'hC0 + i);
    din_src[9] = 8'hD0; din_src[10] = 8'hD1;
    din_last_at = 10;
    din_n = 11;
    burst_len_i = 4'd4;
    fire(1'b1, "R6");
    exp[0] = 32'hC3C2_C1C0; exp[1] = 32'h0000_C5C4;
    exp[2] = 32'h00C8_C7C6; exp[3] = 32'h0000_D1D0;
    check(n_rd == 4, "R6", "read word count", 32'(n_rd), 32'h4);
    check(rd_log[0] == exp[0], "R6", "full packed word", rd_log[0], exp[0]);
    check(rd_log[1] == exp[1], "R7", "length-ended partial word", rd_log[1], exp[1]);
    check(rd_log[2] == exp[2], "R7", "three byte word", rd_log[2], exp[2]);
    check(rd_log[3] == exp[3], "R7", "last-flag early end", rd_log[3], exp[3]);
    check(din_p == 11, "R7", "bytes consumed", 32'(din_p), 32'd11);
    check_bytes(4, "R6");
    check(multi_side == 0, "R12", "single active side", 32'(multi_side), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_mem();
    t_ignored();
    t_write();
    t_replay();
    t_busy_stall();
    t_read();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule